// File: doc/BRIEF.md
# Packed Divide Fault and Flag Checker

This block judges one four-lane single-precision divide. It checks the unit's configuration and the alignment of the memory operand, and it classifies both operands of every lane. From this it picks at most one fault for the instruction and computes the new value of the SIMD status/control word. It does not compute quotients. It sits beside the divider datapath, and the datapath uses its per-lane write enables to decide whether a result may be written back.

An operation is presented for one cycle with `op_valid` high. One clock edge later, the fault code, the lane write enables and the updated status word appear on registered outputs. The status word is an input (the current value) and an output (the value after this operation). Flags only accumulate: this block never clears them.

Top module: `pdx_div_guard`

## Requirements
- R1: Status word layout: bit 0 invalid, bit 1 denormal, bit 2 divide-by-zero, bits 3-5 overflow/underflow/precision, bit 6 denormals-are-zero, bits 7/8/9 mask the invalid/denormal/divide-by-zero flags, bits 10-15 hold the other masks, rounding and flush control. An operation changes only bits 0-5. Flag bits already set stay set, and bits 6-15 are copied unchanged.
- R2: The fault is invalid opcode (code 1) when the SIMD feature is absent, when the emulate bit is 1, or when OS save/restore support is 0.
- R3: The fault is device-not-available (code 2) when the task-switched bit is 1.
- R4: When the operation has a memory operand and `addr_low` (address bits 3:0) is nonzero, the fault is general protection (code 3). A register operand is never checked for alignment.
- R5: Faults are ranked from highest to lowest: configuration invalid opcode, device-not-available, alignment, numeric.
- R6: A lane sets the invalid flag (bit 0) when either source is a signaling NaN (exponent all ones, mantissa MSB 0, mantissa nonzero), when zero is divided by zero, or when infinity is divided by infinity.
- R7: A lane sets the divide-by-zero flag (bit 2) when a finite nonzero dividend is divided by zero.
- R8: A lane sets the denormal flag (bit 1) when a source is denormal, bit 6 is 0, neither source is a NaN and the invalid flag is not set. When bit 6 is 1, denormal sources count as zero.
- R9: If a raised numeric flag has its mask bit at 0, the fault is the SIMD FP exception (code 4) when OS SIMD-exception support is 1, and invalid opcode (code 1) when it is 0. The flags are still recorded.
- R10: With no fault, the fault code is 0 (none) and all four lane write enables are 1. Masked numeric flags are recorded without raising a fault.
- R11: Any fault clears all four lane write enables. A configuration, device or alignment fault leaves the status word equal to its input.
- R12: Outputs change one cycle after `op_valid`. While `op_valid` is low, the fault code is 0, the write enables are 0 and the status word holds. Reset clears all three outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | An operation is presented this cycle |
| dividend | input | 128 | Four dividend lanes, lane i at bits 32i+31:32i |
| divisor | input | 128 | Four divisor lanes, same packing |
| ctl_word_in | input | 16 | Current status/control word |
| cfg_simd_present | input | 1 | SIMD feature reported present |
| cfg_emulate | input | 1 | Emulation forced |
| cfg_task_switched | input | 1 | Task-switched state |
| cfg_os_save | input | 1 | OS save/restore support |
| cfg_os_simd_exc | input | 1 | OS handles SIMD numeric faults |
| mem_operand | input | 1 | Source comes from memory |
| addr_low | input | 4 | Low memory address bits |
| fault_code | output | 3 | 0 none, 1 invalid opcode, 2 device-not-available, 3 general protection, 4 SIMD FP |
| lane_wr_en | output | 4 | Per-lane result commit enable |
| ctl_word_out | output | 16 | Updated status/control word |

## Verification
Ordinary finite quotients set no flag. Against them, lanes carrying a signaling NaN, 0/0, infinity/infinity, x/0 and denormal sources show that each flag is triggered only by its own condition. The same denormal operands run with bit 6 at 0 and at 1, which separates denormal reporting from zero treatment. Each flag also runs with its mask at 1 and at 0, and with both values of OS SIMD-exception support, to cover the three outcomes: record only, SIMD FP fault and invalid-opcode fault. Cases that raise several fault causes together check the priority order, and they also check that a non-numeric fault leaves the status word untouched.

// File: rtl/pdx_pkg.sv
package pdx_pkg;

    localparam int LANES      = 4;
    localparam int FP_W       = 32;
    localparam int EXP_W      = 8;
    localparam int MANT_W     = 23;
    localparam int WORD_W     = 16;
    localparam int ALIGN_BITS = 4;
    localparam int FLAG_N     = 6;

    localparam int B_IE  = 0;
    localparam int B_DE  = 1;
    localparam int B_ZE  = 2;
    localparam int B_DAZ = 6;
    localparam int B_IM  = 7;
    localparam int B_DM  = 8;
    localparam int B_ZM  = 9;

    typedef enum logic [2:0] {
        FLT_NONE = 3'd0,
        FLT_UD   = 3'd1,
        FLT_NM   = 3'd2,
        FLT_GP   = 3'd3,
        FLT_XF   = 3'd4
    } fault_e;

    typedef struct packed {
        logic is_zero;
        logic is_denorm;
        logic is_inf;
        logic is_nan;
        logic is_snan;
    } op_class_t;

    typedef struct packed {
        logic ze;
        logic de;
        logic ie;
    } lane_flags_t;

    function automatic op_class_t classify(input logic [EXP_W-1:0] e,
                                           input logic [MANT_W-1:0] m,
                                           input logic daz);
        op_class_t c;
        logic exp_max, exp_min, m_nz;
        exp_max     = &e;
        exp_min     = ~|e;
        m_nz        = |m;
        c.is_nan    = exp_max & m_nz;
        c.is_snan   = exp_max & m_nz & ~m[MANT_W-1];
        c.is_inf    = exp_max & ~m_nz;
        c.is_denorm = exp_min & m_nz & ~daz;
        c.is_zero   = exp_min & (~m_nz | daz);
        return c;
    endfunction

endpackage

// File: rtl/pdx_lane_check.sv
module pdx_lane_check
    import pdx_pkg::*;
#(
    parameter int W = FP_W
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         daz_i,
    output lane_flags_t  flags_o
);
    localparam int SIGN_POS = W - 1;

    op_class_t ca, cb;
    logic      sign_unused;
    logic      a_finite_nz;

    assign sign_unused = a_i[SIGN_POS] ^ b_i[SIGN_POS];

    always_comb begin
        ca = classify(a_i[W-2 -: EXP_W], a_i[MANT_W-1:0], daz_i);
        cb = classify(b_i[W-2 -: EXP_W], b_i[MANT_W-1:0], daz_i);
        a_finite_nz = ~ca.is_nan & ~ca.is_inf & ~ca.is_zero;

        flags_o.ie = ca.is_snan | cb.is_snan
                   | (ca.is_zero & cb.is_zero)
                   | (ca.is_inf & cb.is_inf);
        flags_o.ze = ~flags_o.ie & cb.is_zero & a_finite_nz;
        flags_o.de = ~flags_o.ie & ~ca.is_nan & ~cb.is_nan
                   & (ca.is_denorm | cb.is_denorm);
    end
endmodule

// File: rtl/pdx_fault_select.sv
module pdx_fault_select
    import pdx_pkg::*;
#(
    parameter int AB = ALIGN_BITS
) (
    input  logic          simd_present_i,
    input  logic          emulate_i,
    input  logic          task_sw_i,
    input  logic          os_save_i,
    input  logic          os_simd_exc_i,
    input  logic          mem_op_i,
    input  logic [AB-1:0] addr_i,
    input  logic          num_unmasked_i,
    output fault_e        fault_o,
    output logic          pre_exec_o
);
    logic cfg_bad, misaligned;

    assign cfg_bad    = ~simd_present_i | emulate_i | ~os_save_i;
    assign misaligned = mem_op_i & (|addr_i);
    assign pre_exec_o = cfg_bad | task_sw_i | misaligned;

    always_comb begin
        if (cfg_bad)             fault_o = FLT_UD;
        else if (task_sw_i)      fault_o = FLT_NM;
        else if (misaligned)     fault_o = FLT_GP;
        else if (num_unmasked_i) fault_o = os_simd_exc_i ? FLT_XF : FLT_UD;
        else                     fault_o = FLT_NONE;
    end
endmodule

// File: rtl/pdx_div_guard.sv
module pdx_div_guard
    import pdx_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   op_valid,
    input  logic [LANES*FP_W-1:0]  dividend,
    input  logic [LANES*FP_W-1:0]  divisor,
    input  logic [WORD_W-1:0]      ctl_word_in,
    input  logic                   cfg_simd_present,
    input  logic                   cfg_emulate,
    input  logic                   cfg_task_switched,
    input  logic                   cfg_os_save,
    input  logic                   cfg_os_simd_exc,
    input  logic                   mem_operand,
    input  logic [ALIGN_BITS-1:0]  addr_low,
    output logic [2:0]             fault_code,
    output logic [LANES-1:0]       lane_wr_en,
    output logic [WORD_W-1:0]      ctl_word_out
);
    localparam int UPPER_W = WORD_W - FLAG_N;

    lane_flags_t lane_fl [LANES];
    lane_flags_t any_fl;
    logic [FLAG_N-1:0] new_flags;
    logic              unmasked;
    logic              pre_exec;
    fault_e            sel_fault;
    logic [WORD_W-1:0] next_word;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        pdx_lane_check #(.W(FP_W)) i_lane (
            .a_i     (dividend[i*FP_W +: FP_W]),
            .b_i     (divisor[i*FP_W +: FP_W]),
            .daz_i   (ctl_word_in[B_DAZ]),
            .flags_o (lane_fl[i])
        );
    end

    always_comb begin
        any_fl = '0;
        for (int i = 0; i < LANES; i++) begin
            any_fl = any_fl | lane_fl[i];
        end
        new_flags        = '0;
        new_flags[B_IE]  = any_fl.ie;
        new_flags[B_DE]  = any_fl.de;
        new_flags[B_ZE]  = any_fl.ze;
        unmasked = (any_fl.ie & ~ctl_word_in[B_IM])
                 | (any_fl.de & ~ctl_word_in[B_DM])
                 | (any_fl.ze & ~ctl_word_in[B_ZM]);
    end

    pdx_fault_select #(.AB(ALIGN_BITS)) i_sel (
        .simd_present_i (cfg_simd_present),
        .emulate_i      (cfg_emulate),
        .task_sw_i      (cfg_task_switched),
        .os_save_i      (cfg_os_save),
        .os_simd_exc_i  (cfg_os_simd_exc),
        .mem_op_i       (mem_operand),
        .addr_i         (addr_low),
        .num_unmasked_i (unmasked),
        .fault_o        (sel_fault),
        .pre_exec_o     (pre_exec)
    );

    assign next_word = pre_exec ? ctl_word_in
                     : {ctl_word_in[WORD_W-1 -: UPPER_W],
                        ctl_word_in[FLAG_N-1:0] | new_flags};

    always_ff @(posedge clk) begin
        if (rst) begin
            fault_code   <= FLT_NONE;
            lane_wr_en   <= '0;
            ctl_word_out <= '0;
        end else if (op_valid) begin
            fault_code   <= sel_fault;
            lane_wr_en   <= (sel_fault == FLT_NONE) ? '1 : '0;
            ctl_word_out <= next_word;
        end else begin
            fault_code   <= FLT_NONE;
            lane_wr_en   <= '0;
        end
    end
endmodule

// File: rtl/pdx_div_guard_chk.sv
module pdx_div_guard_chk
    import pdx_pkg::*;
(
    input logic                  clk,
    input logic                  rst,
    input logic                  op_valid,
    input logic [WORD_W-1:0]     ctl_word_in,
    input logic                  cfg_simd_present,
    input logic                  cfg_emulate,
    input logic                  cfg_task_switched,
    input logic                  cfg_os_save,
    input logic                  mem_operand,
    input logic [ALIGN_BITS-1:0] addr_low,
    input logic [2:0]            fault_code,
    input logic [LANES-1:0]      lane_wr_en,
    input logic [WORD_W-1:0]     ctl_word_out
);
    logic cfg_ok;
    assign cfg_ok = cfg_simd_present & ~cfg_emulate & cfg_os_save;

    // R11
    p_fault_blocks_write_r11: assert property (@(posedge clk) disable iff (rst)
        (fault_code != 3'd0) |-> (lane_wr_en == '0));

    // R1: control bits copied
    p_upper_kept_r1: assert property (@(posedge clk) disable iff (rst)
        op_valid |=> (ctl_word_out[WORD_W-1:FLAG_N] == $past(ctl_word_in[WORD_W-1:FLAG_N])));

    // R1: flags sticky
    p_flags_sticky_r1: assert property (@(posedge clk) disable iff (rst)
        op_valid |=> ((ctl_word_out[FLAG_N-1:0] & $past(ctl_word_in[FLAG_N-1:0]))
                      == $past(ctl_word_in[FLAG_N-1:0])));

    // R3
    p_task_switch_r3: assert property (@(posedge clk) disable iff (rst)
        (op_valid && cfg_ok && cfg_task_switched) |=> (fault_code == 3'd2));

    // R4
    p_misaligned_r4: assert property (@(posedge clk) disable iff (rst)
        (op_valid && cfg_ok && !cfg_task_switched && mem_operand && (addr_low != '0))
        |=> (fault_code == 3'd3));

    // R12
    p_idle_quiet_r12: assert property (@(posedge clk) disable iff (rst)
        !op_valid |=> (fault_code == 3'd0 && lane_wr_en == '0 && $stable(ctl_word_out)));
endmodule

bind pdx_div_guard pdx_div_guard_chk i_chk (.*);

// File: tb/test_pdx_div_guard.sv
module test_pdx_div_guard;
    import pdx_pkg::*;

    localparam logic [31:0] ONE   = 32'h3F80_0000;
    localparam logic [31:0] TWO   = 32'h4000_0000;
    localparam logic [31:0] ZERO  = 32'h0000_0000;
    localparam logic [31:0] INF   = 32'h7F80_0000;
    localparam logic [31:0] NINF  = 32'hFF80_0000;
    localparam logic [31:0] QNAN  = 32'h7FC0_0000;
    localparam logic [31:0] SNAN  = 32'h7F80_0001;
    localparam logic [31:0] DEN   = 32'h0000_0001;
    localparam logic [15:0] DEFW  = 16'h1F80;
    localparam logic [4:0]  CFG_OK = 5'b10011; // present, em, ts, save, simd_exc

    logic         clk = 1'b0;
    logic         rst;
    logic         op_valid;
    logic [127:0] dividend, divisor;
    logic [15:0]  ctl_word_in;
    logic         cfg_simd_present, cfg_emulate, cfg_task_switched, cfg_os_save, cfg_os_simd_exc;
    logic         mem_operand;
    logic [3:0]   addr_low;
    logic [2:0]   fault_code;
    logic [3:0]   lane_wr_en;
    logic [15:0]  ctl_word_out;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    pdx_div_guard i_pdx_div_guard (.*);

    task automatic check(input string req, input string what,
                         input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [127:0] lanes(input logic [31:0] l3, l2, l1, l0);
        return {l3, l2, l1, l0};
    endfunction

    task automatic run_op(input string req, input logic [127:0] a, input logic [127:0] b,
                          input logic [15:0] w, input logic [4:0] cfg,
                          input logic mem, input logic [3:0] addr,
                          input logic [2:0] ef, input logic [3:0] ewr, input logic [15:0] ew);
        @(negedge clk);
        dividend = a; divisor = b; ctl_word_in = w;
        {cfg_simd_present, cfg_emulate, cfg_task_switched, cfg_os_save, cfg_os_simd_exc} = cfg;
        mem_operand = mem; addr_low = addr; op_valid = 1'b1;
        @(negedge clk);
        op_valid = 1'b0;
        check(req, "fault", {13'd0, fault_code}, {13'd0, ef});
        check(req, "wr_en", {12'd0, lane_wr_en}, {12'd0, ewr});
        check(req, "word", ctl_word_out, ew);
    endtask

    localparam logic [127:0] NA = {4{ONE}};
    localparam logic [127:0] NB = {4{TWO}};

    task automatic t_reset;
        check("R12", "reset fault", {13'd0, fault_code}, 16'd0);
        check("R12", "reset wr_en", {12'd0, lane_wr_en}, 16'd0);
        check("R12", "reset word", ctl_word_out, 16'd0);
    endtask

    task automatic t_normal;
        run_op("R10", NA, NB, DEFW, CFG_OK, 1'b1, 4'h0, 3'd0, 4'hF, DEFW);
        run_op("R10", lanes(NINF, QNAN, ONE, TWO), lanes(TWO, ONE, INF, ONE),
               DEFW, CFG_OK, 1'b0, 4'h0, 3'd0, 4'hF, DEFW);
    endtask

    task automatic t_invalid;
        run_op("R6", lanes(ONE, SNAN, ONE, ONE), NB, DEFW, CFG_OK, 1'b0, 4'h0, 3'd0, 4'hF, 16'h1F81);
        run_op("R6", NA, lanes(ONE, ONE, SNAN, ONE), DEFW, CFG_OK, 1'b0, 4'h0, 3'd0, 4'hF, 16'h1F81);
        run_op("R6", lanes(ZERO, ONE, ONE, ONE), lanes(ZERO, ONE, ONE, ONE), DEFW, CFG_OK, 1'b0, 4'h0, 3'd0, 4'hF, 16'h1F81);
        run_op("R6", lanes(ONE, ONE, INF, ONE), lanes(ONE, ONE, NINF, ONE), DEFW, CFG_OK, 1'b0, 4'h0, 3'd0, 4'hF, 16'h1F81);
    endtask

    task automatic t_zero_div;
        run_op("R7", lanes(ONE, ONE, ONE, TWO), lanes(ONE, ONE, ONE, ZERO), DEFW, CFG_OK, 1'b0, 4'h0, 3'd0, 4'hF, 16'h1F84);
        run_op("R7", lanes(ONE, ONE, INF, ONE), lanes(ONE, ONE, ZERO, ONE), DEFW, CFG_OK, 1'b0, 4'h0, 3'd0, 4'hF, DEFW);
        run_op("R7", lanes(ONE, ONE, ONE, TWO), lanes(ONE, ONE, ONE, ZERO), 16'h1D80, CFG_OK, 1'b0, 4'h0, 3'd4, 4'h0, 16'h1D84);
    endtask

    task automatic t_denormal;
        run_op("R8", lanes(ONE, DEN, ONE, ONE), NB, DEFW, CFG_OK, 1'b0, 4'h0, 3'd0, 4'hF, 16'h1F82);
        run_op("R8", lanes(ONE, DEN, ONE, ONE), NB, 16'h1FC0, CFG_OK, 1'b0, 4'h0, 3'd0, 4'hF, 16'h1FC0);
        run_op("R8", lanes(ONE, DEN, ONE, ONE), lanes(ONE, DEN, ONE, ONE), 16'h1FC0, CFG_OK, 1'b0, 4'h0, 3'd0, 4'hF, 16'h1FC1);
        run_op("R8", lanes(ONE, QNAN, ONE, ONE), lanes(ONE, DEN, ONE, ONE), DEFW, CFG_OK, 1'b0, 4'h0, 3'd0, 4'hF, DEFW);
        run_op("R8", lanes(ONE, DEN, ONE, ONE), NB, 16'h1E80, CFG_OK, 1'b0, 4'h0, 3'd4, 4'h0, 16'h1E82);
    endtask

    task automatic t_routing;
        run_op("R9", lanes(ZERO, ONE, ONE, ONE), lanes(ZERO, ONE, ONE, ONE), 16'h1F00, CFG_OK, 1'b0, 4'h0, 3'd4, 4'h0, 16'h1F01);
        run_op("R9", lanes(ZERO, ONE, ONE, ONE), lanes(ZERO, ONE, ONE, ONE), 16'h1F00, 5'b10010, 1'b0, 4'h0, 3'd1, 4'h0, 16'h1F01);
    endtask

    task automatic t_config;
        run_op("R2", lanes(ONE, SNAN, ONE, ONE), NB, DEFW, 5'b00011, 1'b0, 4'h0, 3'd1, 4'h0, DEFW);
        run_op("R2", NA, NB, DEFW, 5'b11011, 1'b0, 4'h0, 3'd1, 4'h0, DEFW);
        run_op("R2", NA, NB, DEFW, 5'b10001, 1'b0, 4'h0, 3'd1, 4'h0, DEFW);
        run_op("R3", lanes(ONE, SNAN, ONE, ONE), NB, DEFW, 5'b10111, 1'b0, 4'h0, 3'd2, 4'h0, DEFW);
    endtask

    task automatic t_align;
        run_op("R4", NA, NB, DEFW, CFG_OK, 1'b1, 4'h8, 3'd3, 4'h0, DEFW);
        run_op("R4", NA, NB, DEFW, CFG_OK, 1'b1, 4'h1, 3'd3, 4'h0, DEFW);
        run_op("R4", NA, NB, DEFW, CFG_OK, 1'b0, 4'h8, 3'd0, 4'hF, DEFW);
    endtask

    task automatic t_priority;
        run_op("R5", NA, NB, DEFW, 5'b11111, 1'b1, 4'h4, 3'd1, 4'h0, DEFW);
        run_op("R5", NA, NB, DEFW, 5'b10111, 1'b1, 4'h4, 3'd2, 4'h0, DEFW);
        run_op("R11", lanes(ONE, SNAN, ONE, ONE), NB, 16'h1F00, CFG_OK, 1'b1, 4'h2, 3'd3, 4'h0, 16'h1F00);
    endtask

    task automatic t_sticky;
        run_op("R1", NA, NB, 16'h1F84, CFG_OK, 1'b0, 4'h0, 3'd0, 4'hF, 16'h1F84);
        run_op("R1", lanes(ONE, SNAN, ONE, ONE), NB, 16'hFFA0, CFG_OK, 1'b0, 4'h0, 3'd0, 4'hF, 16'hFFA1);
    endtask

    task automatic t_idle;
        @(negedge clk);
        ctl_word_in = 16'h0000; dividend = '0; divisor = '0;
        @(negedge clk);
        @(negedge clk);
        check("R12", "idle fault", {13'd0, fault_code}, 16'd0);
        check("R12", "idle wr_en", {12'd0, lane_wr_en}, 16'd0);
        check("R12", "idle word", ctl_word_out, 16'hFFA1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; op_valid = 1'b0; dividend = '0; divisor = '0;
        ctl_word_in = DEFW; {cfg_simd_present, cfg_emulate, cfg_task_switched, cfg_os_save, cfg_os_simd_exc} = CFG_OK;
        mem_operand = 1'b0; addr_low = 4'h0;
        repeat (3) @(negedge clk);
        t_reset();
        rst = 1'b0;
        t_normal();
        t_invalid();
        t_zero_div();
        t_denormal();
        t_routing();
        t_config();
        t_align();
        t_priority();
        t_sticky();
        t_idle();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule